// File: doc/BRIEF.md
# Instruction fetch address remapper

This block sits on the instruction-fetch path of a small core, between the fetch unit and the bus fabric. Each 4 KB block of on-chip RAM has one remap window. A window holds a 20-bit offset into the flash space and an enable flag. When an instruction fetch lands in the flash space, inside the 4 KB page named by an enabled window, the address is steered to the RAM block that belongs to that window, and the access is marked non-cacheable. Any other flash fetch goes to flash unchanged and stays cacheable.

Software loads the windows through a byte-wide write port. Each window has three byte registers: low, middle and high. The enable lives in the high register, and the enable may be set before the other two registers hold their final values. Translation is purely combinational and always uses the current register contents. A fetch that names a RAM address directly is not a legal way to execute code, so it is flagged as illegal. The block produces only the translated address, the target select and the cacheable flag. The memories, the cache and the fabric are outside it.

Top module: `ifr_top`

## Requirements
- R1: After reset every window is disabled. A flash fetch then leaves unchanged on `fetch_addr_o`, with `tgt_ram_o`=0 and `cacheable_o`=1.
- R2: Window n is a hit when all of the following are true:
  - n is enabled;
  - the fetch lies in flash space (`fetch_addr_i` − FLASH_BASE < 2^20);
  - the fetch offset bits 19:12 equal the window base bits 19:12.
  
  On a hit the output is RAM_BASE + n·4096 + `fetch_addr_i`[11:0], with `tgt_ram_o`=1. RAM_BASE is FLASH_BASE + 0x100000. Base bits 11:0 take no part in the compare.
- R3: A hit drives `cacheable_o`=0. A flash fetch that matches no window drives `cacheable_o`=1.
- R4: The register select picks the field to write:
  - select 0 (low) writes base bits 7:0;
  - select 1 (middle) writes base bits 15:8;
  - select 2 (high) writes base bits 19:16 from data bits 3:0, and the enable from data bit 7.
- R5: Matching always uses the current register contents. A window enabled before its low and middle bytes are written matches its partial base, and the new base applies from the clock edge that stores each write.
- R6: When more than one enabled window matches, the lowest-numbered one wins.
- R7: A write to a window index ≥ NUM_WIN changes no window.
- R8: A fetch in the RAM range, [RAM_BASE, RAM_BASE + NUM_WIN·4096), drives:
  - `illegal_o`=1;
  - `tgt_ram_o`=0;
  - `cacheable_o`=0;
  - the address, unchanged.
- R9: A fetch outside both the flash space and the RAM range passes through unchanged, with `cacheable_o`=1, `tgt_ram_o`=0 and `illegal_o`=0.
- R10: With `reg_we_i` low, the write inputs change no window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_win_i | input | IDX_W | Window index of the write |
| reg_sel_i | input | 2 | Byte select: 0 low, 1 middle, 2 high, 3 unused |
| reg_wdata_i | input | 8 | Write data |
| fetch_addr_i | input | ADDR_W | Fetch address from the core |
| fetch_addr_o | output | ADDR_W | Translated fetch address |
| tgt_ram_o | output | 1 | 1 = RAM target, 0 = flash target |
| cacheable_o | output | 1 | Access may be cached |
| illegal_o | output | 1 | Direct fetch from RAM |

## Verification
A register write and a fetch that depends on it can arrive in the same cycle. The fetch must be translated with the contents held before the edge, and the new contents must apply right after that edge. The bench drives a write that enables a window together with a fetch into that window's page. It checks for a miss before the clock edge and for a hit one time step after it. The scoreboard model, updated only when the write commits, supplies both expected values.

// File: rtl/ifr_pkg.sv
package ifr_pkg;
  localparam int unsigned BLK_W = 12;
  localparam int unsigned OFS_W = 20;

  typedef enum logic [1:0] {
    SEL_LO   = 2'd0,
    SEL_MID  = 2'd1,
    SEL_HI   = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             en;
    logic [OFS_W-1:0] base;
  } win_t;
endpackage

// File: rtl/ifr_regfile.sv
module ifr_regfile
  import ifr_pkg::*;
#(
  parameter int unsigned NUM_WIN = 8,
  parameter int unsigned IDX_W   = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [IDX_W-1:0]     win_i,
  input  logic [1:0]           sel_i,
  input  logic [7:0]           wdata_i,
  output win_t [NUM_WIN-1:0]   win_o
);
  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    win_t r_q;
    logic hit_w;
    assign hit_w = we_i && (32'(win_i) == 32'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        r_q <= '0;
      end else if (hit_w) begin
        case (reg_sel_e'(sel_i))
          SEL_LO:  r_q.base[7:0]   <= wdata_i;
          SEL_MID: r_q.base[15:8]  <= wdata_i;
          SEL_HI: begin
            r_q.base[19:16] <= wdata_i[3:0];
            r_q.en          <= wdata_i[7];
          end
          default: ;
        endcase
      end
    end
    assign win_o[g] = r_q;
  end
endmodule

// File: rtl/ifr_match.sv
module ifr_match
  import ifr_pkg::*;
#(
  parameter int unsigned NUM_WIN = 8,
  localparam int unsigned WI_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  win_t [NUM_WIN-1:0] win_i,
  input  logic               in_flash_i,
  input  logic [7:0]         page_i,
  output logic               hit_o,
  output logic [WI_W-1:0]    idx_o
);
  logic [NUM_WIN-1:0] hit_vec;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
    assign hit_vec[g] = win_i[g].en && (win_i[g].base[OFS_W-1:BLK_W] == page_i);
  end

  // lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    idx_o = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit_vec[i]) idx_o = WI_W'(i);
    end
    hit_o = in_flash_i && (|hit_vec);
  end
endmodule

// File: rtl/ifr_xlate.sv
module ifr_xlate
  import ifr_pkg::*;
#(
  parameter int unsigned ADDR_W            = 32,
  parameter logic [ADDR_W-1:0] FLASH_BASE  = 32'h8000_0000,
  parameter int unsigned NUM_WIN           = 8,
  localparam int unsigned WI_W             = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam logic [ADDR_W-1:0] RAM_BASE   = FLASH_BASE + ADDR_W'(1 << OFS_W),
  localparam logic [ADDR_W-1:0] RAM_SIZE   = ADDR_W'(NUM_WIN) << BLK_W,
  localparam logic [ADDR_W-1:0] FLASH_SIZE = ADDR_W'(1) << OFS_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              hit_i,
  input  logic [WI_W-1:0]   idx_i,
  output logic              in_flash_o,
  output logic [7:0]        page_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              tgt_ram_o,
  output logic              cacheable_o,
  output logic              illegal_o
);
  logic [ADDR_W-1:0] flash_ofs, ram_ofs;
  logic              in_ram;

  assign flash_ofs  = addr_i - FLASH_BASE;
  assign ram_ofs    = addr_i - RAM_BASE;
  assign in_flash_o = flash_ofs < FLASH_SIZE;
  assign in_ram     = ram_ofs < RAM_SIZE;
  assign page_o     = flash_ofs[OFS_W-1:BLK_W];

  always_comb begin
    addr_o      = addr_i;
    tgt_ram_o   = 1'b0;
    cacheable_o = 1'b1;
    illegal_o   = 1'b0;
    if (hit_i) begin
      addr_o      = RAM_BASE + ADDR_W'({idx_i, addr_i[BLK_W-1:0]});
      tgt_ram_o   = 1'b1;
      cacheable_o = 1'b0;
    end else if (in_ram) begin
      illegal_o   = 1'b1;
      cacheable_o = 1'b0;
    end
  end
endmodule

// File: rtl/ifr_top.sv
module ifr_top
  import ifr_pkg::*;
#(
  parameter int unsigned ADDR_W           = 32,
  parameter logic [ADDR_W-1:0] FLASH_BASE = 32'h8000_0000,
  parameter int unsigned NUM_WIN          = 8,
  parameter int unsigned IDX_W            = 4,
  localparam int unsigned WI_W            = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [IDX_W-1:0]  reg_win_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [7:0]        reg_wdata_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              tgt_ram_o,
  output logic              cacheable_o,
  output logic              illegal_o
);
  win_t [NUM_WIN-1:0] win_w;
  logic [NUM_WIN-1:0] win_en;
  logic               in_flash, hit;
  logic [7:0]         page;
  logic [WI_W-1:0]    idx;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_en
    assign win_en[g] = win_w[g].en;
  end

  ifr_regfile #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .win_i(reg_win_i), .sel_i(reg_sel_i), .wdata_i(reg_wdata_i),
    .win_o(win_w)
  );

  ifr_match #(.NUM_WIN(NUM_WIN)) u_match (
    .win_i(win_w), .in_flash_i(in_flash), .page_i(page), .hit_o(hit), .idx_o(idx)
  );

  ifr_xlate #(.ADDR_W(ADDR_W), .FLASH_BASE(FLASH_BASE), .NUM_WIN(NUM_WIN)) u_xlate (
    .addr_i(fetch_addr_i), .hit_i(hit), .idx_i(idx),
    .in_flash_o(in_flash), .page_o(page),
    .addr_o(fetch_addr_o), .tgt_ram_o, .cacheable_o, .illegal_o
  );
endmodule

// File: rtl/ifr_chk.sv
module ifr_chk #(
  parameter int unsigned ADDR_W           = 32,
  parameter logic [ADDR_W-1:0] FLASH_BASE = 32'h8000_0000,
  parameter int unsigned NUM_WIN          = 8,
  parameter int unsigned IDX_W            = 4,
  localparam logic [ADDR_W-1:0] RAM_BASE  = FLASH_BASE + ADDR_W'(32'h0010_0000),
  localparam logic [ADDR_W-1:0] RAM_SIZE  = ADDR_W'(NUM_WIN) << 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [IDX_W-1:0]  reg_win_i,
  input logic [ADDR_W-1:0] fetch_addr_i,
  input logic [ADDR_W-1:0] fetch_addr_o,
  input logic              tgt_ram_o,
  input logic              cacheable_o,
  input logic              illegal_o,
  input logic [NUM_WIN-1:0] win_en
);
  // R3
  ram_nc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_ram_o |-> !cacheable_o);
  // R8
  illegal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!tgt_ram_o && !cacheable_o && fetch_addr_o == fetch_addr_i));
  // R2
  ofs_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_ram_o |-> (fetch_addr_o[11:0] == fetch_addr_i[11:0] &&
                   (fetch_addr_o - RAM_BASE) < RAM_SIZE));
  // R9
  pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tgt_ram_o |-> fetch_addr_o == fetch_addr_i);
  // R7
  oob_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && 32'(reg_win_i) >= 32'(NUM_WIN)) |=> $stable(win_en));
  // R10
  no_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_we_i |=> $stable(win_en));
endmodule

bind ifr_top ifr_chk #(.ADDR_W(ADDR_W), .FLASH_BASE(FLASH_BASE), .NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_win_i(reg_win_i),
  .fetch_addr_i(fetch_addr_i), .fetch_addr_o(fetch_addr_o), .tgt_ram_o(tgt_ram_o),
  .cacheable_o(cacheable_o), .illegal_o(illegal_o), .win_en(win_en)
);

// File: tb/sim_ifr_top.sv
module sim_ifr_top;
  localparam int unsigned NW = 8;
  localparam logic [31:0] FB = 32'h8000_0000;
  localparam logic [31:0] RB = 32'h8010_0000;

  typedef struct {
    logic [31:0] addr;
    logic        ram;
    logic        cach;
    logic        ill;
    string       tag;
  } exp_t;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  win = '0;
  logic [1:0]  sel = '0;
  logic [7:0]  wd = '0;
  logic [31:0] fa = '0;
  logic [31:0] fo;
  logic        tr, ca, il;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  exp_t q[$];
  event mon_ev;

  logic [19:0] m_base [NW];
  logic        m_en   [NW];

  always #4 clk = ~clk;

  ifr_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_win_i(win), .reg_sel_i(sel),
    .reg_wdata_i(wd), .fetch_addr_i(fa), .fetch_addr_o(fo), .tgt_ram_o(tr),
    .cacheable_o(ca), .illegal_o(il)
  );

  task automatic model_clear();
    for (int i = 0; i < NW; i++) begin m_base[i] = '0; m_en[i] = 1'b0; end
  endtask

  task automatic model_write(input int w, input int s, input logic [7:0] d);
    if (w < NW) begin
      if (s == 0) m_base[w][7:0] = d;
      else if (s == 1) m_base[w][15:8] = d;
      else if (s == 2) begin m_base[w][19:16] = d[3:0]; m_en[w] = d[7]; end
    end
  endtask

  function automatic exp_t expect_of(input logic [31:0] a, input string tag);
    exp_t e;
    logic [31:0] fo_ofs = a - FB;
    e.addr = a; e.ram = 1'b0; e.cach = 1'b1; e.ill = 1'b0; e.tag = tag;
    if (fo_ofs < 32'h0010_0000) begin
      for (int i = NW - 1; i >= 0; i--)
        if (m_en[i] && m_base[i][19:12] == fo_ofs[19:12]) begin
          e.addr = RB + 32'(i) * 32'd4096 + {20'd0, a[11:0]};
          e.ram = 1'b1; e.cach = 1'b0;
        end
    end else if ((a - RB) < 32'(NW) * 32'd4096) begin
      e.ill = 1'b1; e.cach = 1'b0;
    end
    return e;
  endfunction

  // driver: push expectation, drive fetch, hand to monitor
  task automatic fetch(input logic [31:0] a, input string tag);
    q.push_back(expect_of(a, tag));
    fa = a;
    #1;
    -> mon_ev;
    #1;
  endtask

  task automatic wr(input int w, input int s, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; win = 4'(w); sel = 2'(s); wd = d;
    @(posedge clk); #1;
    we = 1'b0;
    model_write(w, s, d);
  endtask

  // monitor
  initial forever begin
    exp_t e;
    @(mon_ev);
    e = q.pop_front();
    n_chk++;
    if (fo !== e.addr || tr !== e.ram || ca !== e.cach || il !== e.ill) begin
      n_fail++;
      $display("FAIL %s: got addr=%h ram=%b cach=%b ill=%b exp addr=%h ram=%b cach=%b ill=%b",
               e.tag, fo, tr, ca, il, e.addr, e.ram, e.cach, e.ill);
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    fetch(32'h8000_1234, "R1 reset passthrough");
    fetch(32'h8010_0040, "R8 ram block0");
    fetch(32'h8010_7FFC, "R8 ram last byte");
    fetch(32'h8010_8000, "R9 past ram end");
    fetch(32'h0000_1000, "R9 outside");
    // enable first, base partial
    wr(2, 2, 8'h82);
    fetch(32'h8002_0ABC, "R5 enable before mid");
    fetch(32'h8002_0ABC, "R3 hit noncacheable");
    wr(2, 1, 8'h35);
    fetch(32'h8002_0ABC, "R5 old base misses");
    fetch(32'h8002_3FF0, "R2 new base hit");
    wr(2, 0, 8'hFF);
    fetch(32'h8002_3004, "R4 low byte ignored in compare");
    wr(0, 2, 8'h82);
    wr(0, 1, 8'h30);
    fetch(32'h8002_3FF0, "R6 lowest wins");
    wr(0, 2, 8'h02);
    fetch(32'h8002_3FF0, "R4 enable bit cleared");
    wr(9, 2, 8'h81);
    fetch(32'h8001_0000, "R7 out of range index");
    wr(15, 2, 8'h80);
    fetch(32'h8000_0010, "R7 top index");
    @(negedge clk);
    win = 4'd4; sel = 2'd2; wd = 8'h81; we = 1'b0;
    @(posedge clk); #1;
    fetch(32'h8001_0000, "R10 no strobe");
    wr(7, 2, 8'h8F);
    wr(7, 1, 8'hF0);
    fetch(32'h800F_FFFC, "R2 last window top page");
    // same-cycle write and fetch
    @(negedge clk);
    we = 1'b1; win = 4'd5; sel = 2'd2; wd = 8'h84;
    fetch(32'h8004_0100, "R5 same cycle before edge");
    @(posedge clk); #1;
    we = 1'b0;
    model_write(5, 2, 8'h84);
    fetch(32'h8004_0100, "R5 same cycle after edge");
    fetch(32'h8010_5000, "R8 ram with windows on");
    // reset clears
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    model_clear();
    fetch(32'h8002_3FF0, "R1 reset clears enables");
    fetch(32'h8004_0100, "R1 reset clears window 5");
    #10;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule